// File: doc/BRIEF.md
# Compressed-First Fetch and Microcode Sequencer

This block is the instruction front end of a small processor that runs 16-bit compressed instructions natively. It drives a halfword-aligned program counter onto a dedicated 16-bit instruction read port and moves each fetched halfword through two registered stages: decode, then a single execute stage. The execute stage is where the outside logic, such as the ALU and the register file, reads the instruction and its address. One instruction reaches execute per clock unless control is redirected.

The sequencer does not decode a halfword whose two low bits are both 1. It treats that halfword as the first half of a 32-bit instruction and traps to a fixed microcode entry address. It records where user code resumes and exposes the second halfword to the microcode. A small family of custom commands, placed in a reserved corner of the compressed shift-left-immediate encoding, works only in microcode mode. One command returns to user code. The other two signal register moves between the user and microcode banks. Taken branches reported by the execute logic redirect fetch. Every redirect discards the two younger halfwords already in flight.

Top module: `cfetch_seq`

## Requirements
- R1: While reset is held, `imem_addr_o` is 0, `ex_valid_o` is 0 and `ucode_mode_o` is 0. The halfword at address 0 appears in execute on the second rising edge after reset is released.
- R2: With no redirect, execute shows a valid instruction on every cycle, and `ex_pc_o` grows by 2 from one cycle to the next.
- R3: When `br_taken_i` is high with a valid ordinary instruction in execute, the two following halfwords never execute. Execute is empty for two cycles, and then the instruction at `br_target_i` executes.
- R4: A valid instruction in execute with bits [1:0] equal to 11, seen in user mode, sets `ucode_mode_o` on the next cycle. After two empty cycles, execution continues at `UC_ENTRY`.
- R5: On that trap, `upper_half_o` takes the halfword that follows the trapping one, and it holds that value until the next trap.
- R6: A custom command has bits [15:12] = 0001 and bits [1:0] = 10. Bits [3:2] select the operation: 00 returns, 01 moves user to microcode, 10 moves microcode to user, and 11 is reserved. In microcode mode, the return operation clears `ucode_mode_o` and flushes two cycles. Execution then resumes at the trapping address plus 4.
- R7: In microcode mode, the two move operations each raise their own pulse (`mv_u2m_o` or `mv_m2u_o`) for the cycle they sit in execute. They do not disturb the sequential flow.
- R8: Any custom command in user mode, and the reserved command in either mode, raises `illegal_o`. It raises no move pulse, causes no redirect and leaves the mode unchanged.
- R9: A 32-bit instruction seen in microcode mode raises `illegal_o`, causes no redirect, and leaves the saved return address and `upper_half_o` unchanged.
- R10: `imem_addr_o` is always halfword aligned (bit 0 is 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| imem_addr_o | output | PC_W | Byte address of the halfword being fetched |
| imem_data_i | input | 16 | Halfword returned for `imem_addr_o` in the same cycle |
| br_taken_i | input | 1 | Execute logic reports the instruction in execute as a taken branch or jump |
| br_target_i | input | PC_W | Target address of that branch |
| ex_valid_o | output | 1 | Execute stage holds a live instruction |
| ex_instr_o | output | 16 | Halfword in execute |
| ex_pc_o | output | PC_W | Address of the halfword in execute |
| ucode_mode_o | output | 1 | 1 selects the microcode register bank |
| upper_half_o | output | 16 | Second halfword of the last trapped 32-bit instruction |
| illegal_o | output | 1 | Execute holds a command or instruction not allowed in the current mode |
| mv_u2m_o | output | 1 | Move from the user bank to the microcode bank is in execute |
| mv_m2u_o | output | 1 | Move from the microcode bank to the user bank is in execute |

## Verification
The sequencer is driven with five programs. A straight run of no-ops shows the one-per-clock stream and the two-cycle start after reset. A run with one branch marker shows that exactly two slots are dropped and that the target is resumed. A 32-bit instruction followed by a microcode routine of move, move and return separates the trap entry, the capture of the upper halfword and the resume point at plus 4. Custom commands placed in user code, and a 32-bit instruction placed inside microcode, show that illegal use is flagged without any redirect and without corrupting the saved state.

// File: rtl/cf_pkg.sv
package cf_pkg;
  typedef enum logic [2:0] {
    K_PLAIN, K_WIDE, K_RET, K_U2M, K_M2U, K_RSVD
  } kind_e;

  function automatic kind_e classify(input logic [15:0] ins);
    if (ins[1:0] == 2'b11) return K_WIDE;
    if (ins[15:12] == 4'b0001 && ins[1:0] == 2'b10) begin
      case (ins[3:2])
        2'b00:   return K_RET;
        2'b01:   return K_U2M;
        2'b10:   return K_M2U;
        default: return K_RSVD;
      endcase
    end
    return K_PLAIN;
  endfunction
endpackage

// File: rtl/cf_pc_unit.sv
module cf_pc_unit #(
  parameter int unsigned PC_W = 12
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            redirect_i,
  input  logic [PC_W-1:0] target_i,
  output logic [PC_W-1:0] pc_o
);
  localparam logic [PC_W-1:0] STEP = PC_W'(2);
  logic [PC_W-1:0] pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         pc_q <= '0;
    else if (redirect_i) pc_q <= {target_i[PC_W-1:1], 1'b0};
    else                 pc_q <= pc_q + STEP;
  end

  assign pc_o = pc_q;

  a_r10_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_o[0] == 1'b0);
endmodule

// File: rtl/cf_pipe.sv
module cf_pipe #(
  parameter int unsigned PC_W = 12
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            flush_i,
  input  logic [15:0]     fetch_instr_i,
  input  logic [PC_W-1:0] fetch_pc_i,
  output logic            dec_valid_o,
  output logic [15:0]     dec_instr_o,
  output logic            ex_valid_o,
  output logic [15:0]     ex_instr_o,
  output logic [PC_W-1:0] ex_pc_o
);
  logic [PC_W-1:0] dec_pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_valid_o <= 1'b0;
      dec_instr_o <= '0;
      dec_pc_q    <= '0;
      ex_valid_o  <= 1'b0;
      ex_instr_o  <= '0;
      ex_pc_o     <= '0;
    end else begin
      // redirect kills both the halfword in decode and the one being fetched
      dec_valid_o <= !flush_i;
      dec_instr_o <= fetch_instr_i;
      dec_pc_q    <= fetch_pc_i;
      ex_valid_o  <= dec_valid_o && !flush_i;
      ex_instr_o  <= dec_instr_o;
      ex_pc_o     <= dec_pc_q;
    end
  end

  a_r3_flush_kills: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !dec_valid_o && !ex_valid_o);
endmodule

// File: rtl/cf_ctrl.sv
module cf_ctrl
  import cf_pkg::*;
#(
  parameter int unsigned PC_W     = 12,
  parameter int unsigned UC_ENTRY = 'h800
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ex_valid_i,
  input  logic [15:0]     ex_instr_i,
  input  logic [PC_W-1:0] ex_pc_i,
  input  logic [15:0]     dec_instr_i,
  input  logic            br_taken_i,
  input  logic [PC_W-1:0] br_target_i,
  output logic            redirect_o,
  output logic [PC_W-1:0] target_o,
  output logic            trap_o,
  output logic            ucode_mode_o,
  output logic [15:0]     upper_half_o,
  output logic            illegal_o,
  output logic            mv_u2m_o,
  output logic            mv_m2u_o
);
  localparam logic [PC_W-1:0] ENTRY = PC_W'(UC_ENTRY);
  localparam logic [PC_W-1:0] WIDE_LEN = PC_W'(4);

  kind_e           kind;
  logic            is_cmd, ret_go, br_go;
  logic [PC_W-1:0] ret_q;

  always_comb begin
    kind   = classify(ex_instr_i);
    is_cmd = ex_valid_i && (kind inside {K_RET, K_U2M, K_M2U, K_RSVD});
    trap_o = ex_valid_i && kind == K_WIDE && !ucode_mode_o;
    ret_go = is_cmd && ucode_mode_o && kind == K_RET;
    br_go  = ex_valid_i && br_taken_i && kind == K_PLAIN;
    mv_u2m_o  = is_cmd && ucode_mode_o && kind == K_U2M;
    mv_m2u_o  = is_cmd && ucode_mode_o && kind == K_M2U;
    illegal_o = (is_cmd && (!ucode_mode_o || kind == K_RSVD)) ||
                (ex_valid_i && kind == K_WIDE && ucode_mode_o);
    redirect_o = trap_o || ret_go || br_go;
    target_o   = trap_o ? ENTRY : (ret_go ? ret_q : br_target_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ucode_mode_o <= 1'b0;
      ret_q        <= '0;
      upper_half_o <= '0;
    end else if (trap_o) begin
      ucode_mode_o <= 1'b1;
      ret_q        <= ex_pc_i + WIDE_LEN;
      upper_half_o <= dec_instr_i;
    end else if (ret_go) begin
      ucode_mode_o <= 1'b0;
    end
  end

  a_r4_mode_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |=> ucode_mode_o);
  a_r6_mode_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_go |=> !ucode_mode_o);
  a_r8_mode_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |=> ucode_mode_o == $past(ucode_mode_o));
  a_r9_state_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (illegal_o && ucode_mode_o) |=> $stable(ret_q) && $stable(upper_half_o));
  a_r7_one_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({mv_u2m_o, mv_m2u_o, illegal_o, redirect_o}) <= 1);
endmodule

// File: rtl/cfetch_seq.sv
module cfetch_seq #(
  parameter int unsigned PC_W     = 12,
  parameter int unsigned UC_ENTRY = 'h800
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [PC_W-1:0] imem_addr_o,
  input  logic [15:0]     imem_data_i,
  input  logic            br_taken_i,
  input  logic [PC_W-1:0] br_target_i,
  output logic            ex_valid_o,
  output logic [15:0]     ex_instr_o,
  output logic [PC_W-1:0] ex_pc_o,
  output logic            ucode_mode_o,
  output logic [15:0]     upper_half_o,
  output logic            illegal_o,
  output logic            mv_u2m_o,
  output logic            mv_m2u_o
);
  logic            redirect, trap, dec_valid;
  logic [PC_W-1:0] target;
  logic [15:0]     dec_instr;

  cf_pc_unit #(.PC_W(PC_W)) u_pc (
    .clk_i(clk_i), .rst_ni(rst_ni), .redirect_i(redirect),
    .target_i(target), .pc_o(imem_addr_o)
  );

  cf_pipe #(.PC_W(PC_W)) u_pipe (
    .clk_i(clk_i), .rst_ni(rst_ni), .flush_i(redirect),
    .fetch_instr_i(imem_data_i), .fetch_pc_i(imem_addr_o),
    .dec_valid_o(dec_valid), .dec_instr_o(dec_instr),
    .ex_valid_o(ex_valid_o), .ex_instr_o(ex_instr_o), .ex_pc_o(ex_pc_o)
  );

  cf_ctrl #(.PC_W(PC_W), .UC_ENTRY(UC_ENTRY)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .ex_valid_i(ex_valid_o), .ex_instr_i(ex_instr_o), .ex_pc_i(ex_pc_o),
    .dec_instr_i(dec_instr), .br_taken_i(br_taken_i), .br_target_i(br_target_i),
    .redirect_o(redirect), .target_o(target), .trap_o(trap),
    .ucode_mode_o(ucode_mode_o), .upper_half_o(upper_half_o),
    .illegal_o(illegal_o), .mv_u2m_o(mv_u2m_o), .mv_m2u_o(mv_m2u_o)
  );

  a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_valid_o && dec_valid && !redirect) |=>
      ex_valid_o && ex_pc_o == $past(ex_pc_o) + PC_W'(2));
  a_r4_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap |=> imem_addr_o == PC_W'(UC_ENTRY));
  a_r1_reset_pc: assert property (@(posedge clk_i)
    !rst_ni |-> imem_addr_o == '0 && !ex_valid_o);
endmodule

// File: tb/sim_cfetch_seq.sv
`timescale 1ns/1ps
module sim_cfetch_seq;
  localparam int PC_W = 12;
  localparam int ENTRY = 'h800;
  localparam logic [15:0] NOP = 16'h0001;
  localparam logic [15:0] BRM = 16'hA001;
  localparam logic [15:0] C_RET = 16'h1002;
  localparam logic [15:0] C_U2M = 16'h1006;
  localparam logic [15:0] C_M2U = 16'h100A;

  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic [15:0] mem [0:2047];
  logic [PC_W-1:0] imem_addr, br_tgt, ex_pc;
  logic [15:0] imem_data, ex_instr, upper;
  logic br_taken, ex_valid, mode, illegal, u2m, m2u;

  assign imem_data = mem[imem_addr[PC_W-1:1]];
  assign br_taken = ex_valid && ex_instr == BRM;

  cfetch_seq #(.PC_W(PC_W), .UC_ENTRY(ENTRY)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .imem_addr_o(imem_addr), .imem_data_i(imem_data),
    .br_taken_i(br_taken), .br_target_i(br_tgt), .ex_valid_o(ex_valid),
    .ex_instr_o(ex_instr), .ex_pc_o(ex_pc), .ucode_mode_o(mode),
    .upper_half_o(upper), .illegal_o(illegal), .mv_u2m_o(u2m), .mv_m2u_o(m2u)
  );

  int checks = 0, errors = 0;
  logic t_v [0:31];
  logic [PC_W-1:0] t_pc [0:31];
  logic t_md [0:31], t_il [0:31], t_u2m [0:31], t_m2u [0:31];
  logic [15:0] t_up [0:31];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load_nops();
    for (int i = 0; i < 2048; i++) mem[i] = NOP;
    br_tgt = '0;
  endtask

  // hold reset, release at a falling edge, record n cycles (index 0 = release)
  task automatic run(input int n);
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    for (int k = 0; k <= n; k++) begin
      if (k > 0) @(negedge clk);
      t_v[k] = ex_valid; t_pc[k] = ex_pc; t_md[k] = mode; t_il[k] = illegal;
      t_u2m[k] = u2m; t_m2u[k] = m2u; t_up[k] = upper;
    end
  endtask

  task automatic t_reset_seq();
    load_nops();
    rst_n = 0;
    repeat (2) @(negedge clk);
    chk("R1 addr in reset", 32'(imem_addr), 0);
    chk("R1 ex_valid in reset", 32'(ex_valid), 0);
    chk("R1 mode in reset", 32'(mode), 0);
    run(10);
    chk("R1 idx1 empty", 32'(t_v[1]), 0);
    chk("R1 idx2 valid", 32'(t_v[2]), 1);
    chk("R1 idx2 pc", 32'(t_pc[2]), 0);
    for (int k = 3; k <= 10; k++) begin
      chk("R2 valid each cycle", 32'(t_v[k]), 1);
      chk("R2 pc step", 32'(t_pc[k]), 32'((k - 2) * 2));
    end
  endtask

  task automatic t_branch();
    load_nops();
    mem[3] = BRM; br_tgt = 12'h040;
    run(10);
    chk("R3 branch executes", 32'(t_pc[5]), 6);
    chk("R3 bubble 1", 32'(t_v[6]), 0);
    chk("R3 bubble 2", 32'(t_v[7]), 0);
    chk("R3 target valid", 32'(t_v[8]), 1);
    chk("R3 target pc", 32'(t_pc[8]), 'h40);
    chk("R3 after target", 32'(t_pc[9]), 'h42);
    chk("R3 mode untouched", 32'(t_md[9]), 0);
  endtask

  task automatic t_trap_return();
    load_nops();
    mem[2] = 16'h1233; mem[3] = 16'hABCD;
    mem[ENTRY/2] = C_U2M; mem[ENTRY/2 + 1] = C_M2U; mem[ENTRY/2 + 2] = C_RET;
    run(14);
    chk("R4 trap pc in ex", 32'(t_pc[4]), 4);
    chk("R4 mode set", 32'(t_md[5]), 1);
    chk("R4 bubble", 32'(t_v[5] | t_v[6]), 0);
    chk("R4 entry pc", 32'(t_pc[7]), ENTRY);
    chk("R4 entry valid", 32'(t_v[7]), 1);
    chk("R5 upper half", 32'(t_up[5]), 'hABCD);
    chk("R7 u2m pulse", 32'({t_u2m[7], t_m2u[7]}), 2'b10);
    chk("R7 m2u pulse", 32'({t_u2m[8], t_m2u[8]}), 2'b01);
    chk("R7 flow kept", 32'(t_pc[9]), ENTRY + 4);
    chk("R7 pulse ends", 32'({t_u2m[9], t_m2u[9], t_il[9]}), 0);
    chk("R6 mode cleared", 32'(t_md[10]), 0);
    chk("R6 bubble", 32'(t_v[10] | t_v[11]), 0);
    chk("R6 resume pc", 32'(t_pc[12]), 8);
    chk("R6 resume valid", 32'(t_v[12]), 1);
    chk("R5 upper held", 32'(t_up[12]), 'hABCD);
  endtask

  task automatic t_user_cmds();
    load_nops();
    mem[1] = C_RET; mem[2] = C_U2M; mem[3] = 16'h100E;
    run(8);
    chk("R8 ret illegal", 32'(t_il[3]), 1);
    chk("R8 u2m illegal", 32'(t_il[4]), 1);
    chk("R8 no pulse", 32'(t_u2m[4]), 0);
    chk("R8 rsvd illegal", 32'(t_il[5]), 1);
    chk("R8 no redirect", 32'({t_v[5], t_v[6]}), 2'b11);
    chk("R8 pc continues", 32'(t_pc[6]), 8);
    chk("R8 mode kept", 32'(t_md[6]), 0);
  endtask

  task automatic t_nested_wide();
    load_nops();
    mem[0] = 16'h0013; mem[1] = 16'h5555;
    mem[ENTRY/2] = 16'h0013; mem[ENTRY/2 + 2] = C_RET;
    run(12);
    chk("R9 illegal in ucode", 32'(t_il[5]), 1);
    chk("R9 mode kept", 32'(t_md[6]), 1);
    chk("R9 no redirect", 32'(t_pc[6]), ENTRY + 2);
    chk("R9 upper kept", 32'(t_up[6]), 'h5555);
    chk("R9 resume addr kept", 32'(t_pc[10]), 4);
    chk("R6 resume valid", 32'(t_v[10]), 1);
  endtask

  initial begin
    br_tgt = '0;
    load_nops();
    t_reset_seq();
    t_branch();
    t_trap_return();
    t_user_cmds();
    t_nested_wide();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule